// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised storage and shift register (eight bits by default) whose parallel data lines form a single shared, bidirectional bus. When the block drives the bus it presents its current contents. When the block releases the bus, another agent can place a word on the same lines, and that word is captured on a load. Two select inputs choose one of four operations: hold the contents, shift toward the most significant bit, shift toward the least significant bit, or load the bus value. All of these operations take effect on the rising clock edge.

Each end bit also has its own serial input and its own serial output. The serial outputs are always driven, so several instances can be chained into a longer word. An active-low reset clears the register at once, without waiting for the clock. Two active-low enables gate the bus drivers. The drivers also release the bus by themselves whenever load is selected, so an external agent can drive the load word without contention. Register operation continues while the bus is released. A separate output always shows the value present on the bus lines.

Top module: `usr_bidir_shift`

## Requirements
- R1: With select code 2'b00 (sel[1] first), the register keeps its contents across a rising clock edge.
- R2: With select code 2'b01, on the rising edge each bit i moves to bit i+1, and ser_lsb_in enters bit 0.
- R3: With select code 2'b10, on the rising edge each bit i moves to bit i-1, and ser_msb_in enters the top bit.
- R4: With select code 2'b11, the value on the bus lines is captured into every bit on the rising edge.
- R5: While rst_n is low, the register is zero without waiting for a clock edge, whatever the clock and the selects do. After rst_n rises, the register stays zero until the next rising edge.
- R6: The block drives its contents onto the bus only when oe_a_n and oe_b_n are both low and the select code is not 2'b11. Otherwise it leaves the bus undriven, and bus_rd follows whatever an external agent drives.
- R7: Hold, both shifts, load and reset behave the same whether or not the bus drivers are enabled.
- R8: ser_lsb_out always equals bit 0 and ser_msb_out always equals the top bit, independent of the enables and the select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear |
| sel | input | 2 | Operation select: 00 hold, 01 toward MSB, 10 toward LSB, 11 load |
| ser_lsb_in | input | 1 | Serial bit entering bit 0 when shifting toward the MSB |
| ser_msb_in | input | 1 | Serial bit entering the top bit when shifting toward the LSB |
| oe_a_n | input | 1 | Active-low bus output enable, first of two |
| oe_b_n | input | 1 | Active-low bus output enable, second of two |
| bus | inout | W | Shared parallel bus: register contents out, load data in |
| bus_rd | output | W | Value currently present on the bus lines |
| ser_lsb_out | output | 1 | Always-driven copy of bit 0 |
| ser_msb_out | output | 1 | Always-driven copy of the top bit |

## Verification
The hardest situation to reach is the bus hand-over. Whenever the block must be silent, the external agent has to drive the lines, and it must be quiet in exactly the cycles when the block drives. Otherwise the observed value is a contention artefact rather than the register contents. The bench computes, from the select code and the two enables, when the block should release the bus. It drives a changing word in precisely those cycles, which include shifts and holds with an enable high. It then checks that the register still evolves, reading it through the serial outputs and through the bus once the drivers come back. The asynchronous clear is also applied in the middle of a clock period, and then held low across a load edge to show that it overrides the clock.

// File: rtl/usr_pkg.sv
// Package with the operation encoding shared by the shift register modules.
// Assumes a two-bit select in which the MSB-side select line is bit 1.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'b00,
        MODE_TO_MSB = 2'b01,
        MODE_TO_LSB = 2'b10,
        MODE_LOAD   = 2'b11
    } mode_e;
endpackage

// File: rtl/usr_ctrl.sv
// Control decode: turns the raw select and the two enables into an
// operation code and a bus-drive qualifier.
// Assumes: enables are active low, and load always releases the bus.
module usr_ctrl
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output mode_e      mode,
    output logic       drive_en
);
    // Map the select pins onto the operation type.
    always_comb begin
        mode = mode_e'(sel);
    end

    // Drive only with both enables low and load not selected.
    always_comb begin
        drive_en = !oe_a_n && !oe_b_n && (sel != 2'b11);
    end
endmodule

// File: rtl/usr_stage_reg.sv
// Register core: W flip-flops with a per-bit next-value selector for
// hold, shift toward MSB, shift toward LSB and parallel load.
// Assumes: rst_n is an asynchronous active-low clear, and par_in is
// stable around the rising edge when loading.
module usr_stage_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic         ser_lsb_in,
    input  logic         ser_msb_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    localparam int TOP = W - 1;

    logic [W-1:0] d;

    // Per-bit next value; the end bits take the serial inputs.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_lo_end
            assign from_lo = ser_lsb_in;
        end else begin : g_lo_mid
            assign from_lo = q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign from_hi = ser_msb_in;
        end else begin : g_hi_mid
            assign from_hi = q[i+1];
        end
        assign d[i] = (mode == MODE_HOLD)   ? q[i]    :
                      (mode == MODE_TO_MSB) ? from_lo :
                      (mode == MODE_TO_LSB) ? from_hi : par_in[i];
    end

    // State update with asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q));
    // R2
    shift_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TO_MSB) |=> (q == {$past(q[TOP-1:0]), $past(ser_lsb_in)}));
    // R3
    shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TO_LSB) |=> (q == {$past(ser_msb_in), $past(q[TOP:1])}));
    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(par_in)));
endmodule

// File: rtl/usr_bus_port.sv
// Bus port: tri-state driver for the shared parallel lines plus a
// read path that returns whatever value is present on them.
// Assumes: any external agent drives only while en is low.
module usr_bus_port #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] data,
    inout  wire  [W-1:0] bus,
    output logic [W-1:0] rd
);
    // Drive the contents or release the lines.
    assign bus = en ? data : {W{1'bz}};
    // Observe the resolved line value.
    assign rd  = bus;
endmodule

// File: rtl/usr_bidir_shift.sv
// Top level: universal shift register sharing one bidirectional bus for
// parallel load data and parallel read-out, with serial end outputs.
// Assumes: an external agent drives the bus only while the block is silent.
module usr_bidir_shift
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         ser_lsb_in,
    input  logic         ser_msb_in,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    inout  wire  [W-1:0] bus,
    output logic [W-1:0] bus_rd,
    output logic         ser_lsb_out,
    output logic         ser_msb_out
);
    localparam int TOP = W - 1;

    mode_e        mode;
    logic         drive_en;
    logic [W-1:0] q;

    usr_ctrl u_ctrl (
        .sel      (sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .mode     (mode),
        .drive_en (drive_en)
    );

    usr_stage_reg #(.W(W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .ser_lsb_in (ser_lsb_in),
        .ser_msb_in (ser_msb_in),
        .par_in     (bus_rd),
        .q          (q)
    );

    usr_bus_port #(.W(W)) u_port (
        .en   (drive_en),
        .data (q),
        .bus  (bus),
        .rd   (bus_rd)
    );

    // Serial end taps, never tri-stated.
    assign ser_lsb_out = q[0];
    assign ser_msb_out = q[TOP];

    // R6
    load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> !drive_en);
    // R6
    enable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !drive_en);
endmodule

// File: tb/tb_usr_bidir_shift.sv
// Bench: behavioural reference model updated each rising edge and compared
// at every falling edge. An external bus agent drives only when the block
// is expected to be silent.
module tb_usr_bidir_shift;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       li = 1'b0, hi = 1'b0, oa = 1'b0, ob = 1'b0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_val = 8'h00;
    wire  [7:0] bus;
    logic [7:0] bus_rd;
    logic       so_lo, so_hi;
    logic [7:0] m = 8'h00;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    assign bus = tb_drv ? tb_val : 8'hzz;

    usr_bidir_shift #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_lsb_in(li), .ser_msb_in(hi),
        .oe_a_n(oa), .oe_b_n(ob), .bus(bus), .bus_rd(bus_rd),
        .ser_lsb_out(so_lo), .ser_msb_out(so_hi)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all visible outputs against the model.
    task automatic compare(input string req);
        chk({req, " R8 lsb tap"}, {7'b0, so_lo}, {7'b0, m[0]});
        chk({req, " R8 msb tap"}, {7'b0, so_hi}, {7'b0, m[7]});
        if (!tb_drv) chk({req, " R6 bus drive"}, bus_rd, m);
        else         chk({req, " R6 bus released"}, bus_rd, tb_val);
    endtask

    // One clock: apply inputs at the falling edge, update model, check.
    task automatic step(input logic [1:0] s, input logic l, input logic h,
                        input logic a, input logic b, input logic [7:0] v,
                        input string req);
        sel = s; li = l; hi = h; oa = a; ob = b;
        tb_drv = (s == 2'b11) || a || b;
        tb_val = v;
        @(posedge clk);
        case (s)
            2'b00: m = m;
            2'b01: m = {m[6:0], l};
            2'b10: m = {h, m[7:1]};
            default: m = v;
        endcase
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        compare("R5 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R5 after release");
        step(2'b11, 0, 0, 0, 0, 8'hA5, "R4 load A5");
        step(2'b00, 0, 0, 0, 0, 8'h00, "R1 hold");
        step(2'b00, 1, 1, 0, 0, 8'h00, "R1 hold with serial ones");
        step(2'b01, 1, 0, 0, 0, 8'h00, "R2 to msb one");
        step(2'b01, 0, 1, 0, 0, 8'h00, "R2 to msb zero");
        step(2'b10, 0, 1, 0, 0, 8'h00, "R3 to lsb one");
        step(2'b10, 1, 0, 0, 0, 8'h00, "R3 to lsb zero");
        step(2'b11, 0, 0, 1, 0, 8'h3C, "R4 load with oe_a high");
        // R7: register keeps working with the drivers off.
        step(2'b01, 1, 0, 1, 0, 8'hFF, "R7 shift msb oe_a high");
        step(2'b10, 0, 1, 0, 1, 8'h11, "R7 shift lsb oe_b high");
        step(2'b00, 1, 1, 1, 1, 8'hEE, "R7 hold both high");
        step(2'b00, 0, 0, 0, 0, 8'h00, "R7 drivers back");
        for (int k = 0; k < 8; k++) step(2'b01, 1'(k % 2), 0, 0, 0, 8'h00, "R2 walk");
        for (int k = 0; k < 8; k++) step(2'b10, 0, 1'(k < 3), 0, 1, 8'h5A, "R3 walk");
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0], lfsr[2], lfsr[3], lfsr[4] & lfsr[5], lfsr[6] & lfsr[7],
                 lfsr[15:8], "R1 R2 R3 R4 R7 mix");
        end
        step(2'b11, 0, 0, 0, 0, 8'hC3, "R4 load before reset");
        // R5: asynchronous clear in mid-period, then held across a load edge.
        sel = 2'b00; tb_drv = 1'b0; oa = 1'b0; ob = 1'b0;
        #5 rst_n = 1'b0;
        #2 m = 8'h00;
        compare("R5 async clear");
        @(negedge clk);
        sel = 2'b11; tb_drv = 1'b1; tb_val = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        compare("R5 overrides load");
        sel = 2'b00; tb_drv = 1'b0;
        rst_n = 1'b1;
        #3 compare("R5 zero after release");
        @(negedge clk);
        compare("R5 zero at hold edge");
        step(2'b01, 1, 0, 0, 0, 8'h00, "R2 after reset");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule